// File: doc/BRIEF.md
# GPIO Bank with Dual Interrupt Lines

This block is a 32-pin general-purpose I/O bank behind a 32-bit register port. Each pin is either an input or a driven output, chosen by a per-pin direction bit. An input pin can be set to flag a rising edge, a falling edge, a high level, a low level, or any mix of them. A detected condition raises the pin's bit in two separate status words. Each status word has its own enable word and its own interrupt line, so two different consumers can be served from the same pins. A wakeup request line pulses when a watched pin fires, but only while the configuration word selects an idle mode and has wakeup turned on.

Software uses plain read and write cycles. A write is taken on the clock edge where `wrEn` is high. Read data follows `addr` combinationally. For the interrupt enables, the wakeup enables and the output data word there are extra addresses that only set or only clear the written 1-bits, so one field can change without a read-modify-write. Level conditions are evaluated on every cycle. As a result, a status bit whose level condition still holds comes back at once after a clear. The debounce enable and debounce time words are storage only.

Top module: `gpio_bank`

## Requirements
- R1: After reset the register values are as follows. Direction (0x34) reads all ones. Control (0x30) reads 2. System status (0x14) reads 1. Revision (0x00) reads the parameter `REV_ID` (default 0x2A). Every enable, status, detect, wakeup and debounce word reads 0, and so does data out. Both interrupt lines, `wakeReq` and `pinOutEn` are 0.
- R2: Take an input pin (direction bit 1) whose rising-detect bit (0x48) is set. A 0-to-1 change on it sets the same bit in status A (0x18) and status B (0x28) on the second clock edge after the change.
- R3: A falling-detect bit (0x4C) flags 1-to-0 changes in the same way. Edges on pins with direction bit 0, or with no enabled detect bit, set no status.
- R4: With a high-level (0x44) or low-level (0x40) detect bit set, the status bit is set while an input pin holds that level. It is set again on the next edge after a clear while the level still holds.
- R5: Writing status A or status B clears only the bits written as 1 and leaves the other status word unchanged.
- R6: `irqA` is 1 exactly when some bit is set in both status A and enable A (0x1C). `irqB` is formed the same way from status B and enable B (0x2C).
- R7: These addresses clear or set the written 1-bits of a field: 0x60/0x64 for enable A, 0x70/0x74 for enable B, 0x80/0x84 for wakeup enable (0x20), and 0x90/0x94 for data out (0x3C). Reading any of them returns the field.
- R8: `pinOutEn` is the inverse of direction. `pinOut` carries data out only on pins whose direction bit is 0 and is 0 elsewhere.
- R9: `wakeReq` is asserted one cycle after a detected event on a pin. This needs the pin's wakeup-enable bit, configuration bit 2, and a nonzero configuration field in bits 4:3.
- R10: A write to configuration (0x10) stores the value AND 0x1D. If bit 1 of the written value is 1, all registers except data out also return to their reset values.
- R11: Control keeps written bits 2:0. Writes to revision, system status and data in (0x38) change nothing. Unmapped addresses read 0.
- R12: If a status-clear write and a new event for the same bit fall on the same edge, the bit ends set.
- R13: Debounce enable (0x50) stores 32 bits and debounce time (0x54) stores 8 bits, with no effect on detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pinIn | input | 32 | Pin input levels |
| pinOut | output | 32 | Driven pin values |
| pinOutEn | output | 32 | Per-pin drive enable |
| irqA | output | 1 | Interrupt line A |
| irqB | output | 1 | Interrupt line B |
| wakeReq | output | 1 | Wakeup request |

## Verification
The case that needs care is a status-clear write landing on the same edge that a new edge event sets that same bit. The bench changes the pin one cycle before the clear write, so the detected event and the write strobe meet at one clock edge. The bit must then read as set, in both status words. A second clear with no new edge must then leave it at 0, which shows that the earlier result was the event winning and not a clear that failed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register byte addresses
  localparam logic [7:0] A_REV     = 8'h00;
  localparam logic [7:0] A_CFG     = 8'h10;
  localparam logic [7:0] A_SYSST   = 8'h14;
  localparam logic [7:0] A_STATA   = 8'h18;
  localparam logic [7:0] A_ENA     = 8'h1C;
  localparam logic [7:0] A_WAKE    = 8'h20;
  localparam logic [7:0] A_STATB   = 8'h28;
  localparam logic [7:0] A_ENB     = 8'h2C;
  localparam logic [7:0] A_CTRL    = 8'h30;
  localparam logic [7:0] A_DIR     = 8'h34;
  localparam logic [7:0] A_DIN     = 8'h38;
  localparam logic [7:0] A_DOUT    = 8'h3C;
  localparam logic [7:0] A_LVLLO   = 8'h40;
  localparam logic [7:0] A_LVLHI   = 8'h44;
  localparam logic [7:0] A_RISE    = 8'h48;
  localparam logic [7:0] A_FALL    = 8'h4C;
  localparam logic [7:0] A_DBEN    = 8'h50;
  localparam logic [7:0] A_DBT     = 8'h54;
  localparam logic [7:0] A_ENACLR  = 8'h60;
  localparam logic [7:0] A_ENASET  = 8'h64;
  localparam logic [7:0] A_ENBCLR  = 8'h70;
  localparam logic [7:0] A_ENBSET  = 8'h74;
  localparam logic [7:0] A_WAKECLR = 8'h80;
  localparam logic [7:0] A_WAKESET = 8'h84;
  localparam logic [7:0] A_DOUTCLR = 8'h90;
  localparam logic [7:0] A_DOUTSET = 8'h94;

  localparam int          CFG_W    = 5;
  localparam logic [4:0]  CFG_KEEP = 5'b11101;
  localparam int          CFG_SRST = 1;
  localparam int          CFG_WEN  = 2;
  localparam int          CTRL_W   = 3;
  localparam logic [2:0]  CTRL_RST = 3'd2;

  typedef struct packed {
    logic cfgWr;
    logic statAClr;
    logic statBClr;
    logic enAWr;
    logic enAClr;
    logic enASet;
    logic enBWr;
    logic enBClr;
    logic enBSet;
    logic wakeWr;
    logic wakeClr;
    logic wakeSet;
    logic ctrlWr;
    logic dirWr;
    logic outWr;
    logic outClr;
    logic outSet;
    logic lvlLoWr;
    logic lvlHiWr;
    logic riseWr;
    logic fallWr;
    logic dbEnWr;
    logic dbTimeWr;
  } bankStrobes_t;

  typedef enum logic [4:0] {
    RD_NONE, RD_REV, RD_CFG, RD_SYSST, RD_STATA, RD_ENA, RD_WAKE,
    RD_STATB, RD_ENB, RD_CTRL, RD_DIR, RD_DIN, RD_DOUT, RD_LVLLO,
    RD_LVLHI, RD_RISE, RD_FALL, RD_DBEN, RD_DBT
  } rdSel_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobes_t      strb,
  output rdSel_t            rdSel
);

  logic [7:0] regAddr;
  assign regAddr = 8'(addr);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (regAddr)
        A_CFG:     strb.cfgWr    = 1'b1;
        A_STATA:   strb.statAClr = 1'b1;
        A_STATB:   strb.statBClr = 1'b1;
        A_ENA:     strb.enAWr    = 1'b1;
        A_ENACLR:  strb.enAClr   = 1'b1;
        A_ENASET:  strb.enASet   = 1'b1;
        A_ENB:     strb.enBWr    = 1'b1;
        A_ENBCLR:  strb.enBClr   = 1'b1;
        A_ENBSET:  strb.enBSet   = 1'b1;
        A_WAKE:    strb.wakeWr   = 1'b1;
        A_WAKECLR: strb.wakeClr  = 1'b1;
        A_WAKESET: strb.wakeSet  = 1'b1;
        A_CTRL:    strb.ctrlWr   = 1'b1;
        A_DIR:     strb.dirWr    = 1'b1;
        A_DOUT:    strb.outWr    = 1'b1;
        A_DOUTCLR: strb.outClr   = 1'b1;
        A_DOUTSET: strb.outSet   = 1'b1;
        A_LVLLO:   strb.lvlLoWr  = 1'b1;
        A_LVLHI:   strb.lvlHiWr  = 1'b1;
        A_RISE:    strb.riseWr   = 1'b1;
        A_FALL:    strb.fallWr   = 1'b1;
        A_DBEN:    strb.dbEnWr   = 1'b1;
        A_DBT:     strb.dbTimeWr = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      A_REV:                        rdSel = RD_REV;
      A_CFG:                        rdSel = RD_CFG;
      A_SYSST:                      rdSel = RD_SYSST;
      A_STATA:                      rdSel = RD_STATA;
      A_ENA, A_ENACLR, A_ENASET:    rdSel = RD_ENA;
      A_WAKE, A_WAKECLR, A_WAKESET: rdSel = RD_WAKE;
      A_STATB:                      rdSel = RD_STATB;
      A_ENB, A_ENBCLR, A_ENBSET:    rdSel = RD_ENB;
      A_CTRL:                       rdSel = RD_CTRL;
      A_DIR:                        rdSel = RD_DIR;
      A_DIN:                        rdSel = RD_DIN;
      A_DOUT, A_DOUTCLR, A_DOUTSET: rdSel = RD_DOUT;
      A_LVLLO:                      rdSel = RD_LVLLO;
      A_LVLHI:                      rdSel = RD_LVLHI;
      A_RISE:                       rdSel = RD_RISE;
      A_FALL:                       rdSel = RD_FALL;
      A_DBEN:                       rdSel = RD_DBEN;
      A_DBT:                        rdSel = RD_DBT;
      default:                      rdSel = RD_NONE;
    endcase
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strb) <= 1);

endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinIn,
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] riseEn,
  input  logic [PINS-1:0] fallEn,
  input  logic [PINS-1:0] lvlLoEn,
  input  logic [PINS-1:0] lvlHiEn,
  output logic [PINS-1:0] dataIn,
  output logic [PINS-1:0] evt
);

  logic [PINS-1:0] prevIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataIn <= '0;
      prevIn <= '0;
    end else begin
      dataIn <= pinIn;
      prevIn <= dataIn;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic isRise, isFall, isHi, isLo;
    assign isRise = dataIn[p] & ~prevIn[p] & riseEn[p];
    assign isFall = ~dataIn[p] & prevIn[p] & fallEn[p];
    assign isHi   = dataIn[p] & lvlHiEn[p];
    assign isLo   = ~dataIn[p] & lvlLoEn[p];
    assign evt[p] = dir[p] & (isRise | isFall | isHi | isLo);
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int         PINS   = 32,
  parameter int         DBT_W  = 8,
  parameter logic [7:0] REV_ID = 8'h2A
) (
  input  logic            clk,
  input  logic            rstN,
  input  bankStrobes_t    strb,
  input  rdSel_t          rdSel,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] pinIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOutEn,
  output logic            irqA,
  output logic            irqB,
  output logic            wakeReq
);

  logic [CFG_W-1:0]  cfg;
  logic [CTRL_W-1:0] ctrl;
  logic [PINS-1:0]   statA, statB, enA, enB, wakeEn, dir, dataOut;
  logic [PINS-1:0]   lvlLo, lvlHi, riseEn, fallEn, dbEn;
  logic [DBT_W-1:0]  dbTime;
  logic [PINS-1:0]   dataIn, evt;
  logic [PINS-1:0]   clrMaskA, clrMaskB;
  logic              softRst, wakeGate;

  gpio_bank_detect #(.PINS(PINS)) u_detect (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .dir     (dir),
    .riseEn  (riseEn),
    .fallEn  (fallEn),
    .lvlLoEn (lvlLo),
    .lvlHiEn (lvlHi),
    .dataIn  (dataIn),
    .evt     (evt)
  );

  assign softRst  = strb.cfgWr & wdata[CFG_SRST];
  assign clrMaskA = strb.statAClr ? wdata : '0;
  assign clrMaskB = strb.statBClr ? wdata : '0;
  assign wakeGate = cfg[CFG_WEN] & (cfg[4:3] != 2'b00);

  // Configuration word: always takes the masked write value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfg <= '0;
    else if (strb.cfgWr)  cfg <= wdata[CFG_W-1:0] & CFG_KEEP;
  end

  // Data out survives a soft reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataOut <= '0;
    else if (strb.outWr)   dataOut <= wdata;
    else if (strb.outClr)  dataOut <= dataOut & ~wdata;
    else if (strb.outSet)  dataOut <= dataOut | wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl <= CTRL_RST;  dir <= '1;
      statA <= '0;  statB <= '0;  enA <= '0;  enB <= '0;  wakeEn <= '0;
      lvlLo <= '0;  lvlHi <= '0;  riseEn <= '0;  fallEn <= '0;
      dbEn <= '0;   dbTime <= '0; wakeReq <= 1'b0;
    end else if (softRst) begin
      ctrl <= CTRL_RST;  dir <= '1;
      statA <= '0;  statB <= '0;  enA <= '0;  enB <= '0;  wakeEn <= '0;
      lvlLo <= '0;  lvlHi <= '0;  riseEn <= '0;  fallEn <= '0;
      dbEn <= '0;   dbTime <= '0; wakeReq <= 1'b0;
    end else begin
      // New events win over a clear of the same bit
      statA   <= (statA & ~clrMaskA) | evt;
      statB   <= (statB & ~clrMaskB) | evt;
      wakeReq <= wakeGate & |(evt & wakeEn);

      if (strb.enAWr)        enA <= wdata;
      else if (strb.enAClr)  enA <= enA & ~wdata;
      else if (strb.enASet)  enA <= enA | wdata;

      if (strb.enBWr)        enB <= wdata;
      else if (strb.enBClr)  enB <= enB & ~wdata;
      else if (strb.enBSet)  enB <= enB | wdata;

      if (strb.wakeWr)       wakeEn <= wdata;
      else if (strb.wakeClr) wakeEn <= wakeEn & ~wdata;
      else if (strb.wakeSet) wakeEn <= wakeEn | wdata;

      if (strb.ctrlWr)   ctrl   <= wdata[CTRL_W-1:0];
      if (strb.dirWr)    dir    <= wdata;
      if (strb.lvlLoWr)  lvlLo  <= wdata;
      if (strb.lvlHiWr)  lvlHi  <= wdata;
      if (strb.riseWr)   riseEn <= wdata;
      if (strb.fallWr)   fallEn <= wdata;
      if (strb.dbEnWr)   dbEn   <= wdata;
      if (strb.dbTimeWr) dbTime <= wdata[DBT_W-1:0];
    end
  end

  assign irqA     = |(statA & enA);
  assign irqB     = |(statB & enB);
  assign pinOutEn = ~dir;
  assign pinOut   = dataOut & ~dir;

  always_comb begin
    unique case (rdSel)
      RD_REV:   rdata = PINS'(REV_ID);
      RD_CFG:   rdata = PINS'(cfg);
      RD_SYSST: rdata = PINS'(1);
      RD_STATA: rdata = statA;
      RD_ENA:   rdata = enA;
      RD_WAKE:  rdata = wakeEn;
      RD_STATB: rdata = statB;
      RD_ENB:   rdata = enB;
      RD_CTRL:  rdata = PINS'(ctrl);
      RD_DIR:   rdata = dir;
      RD_DIN:   rdata = dataIn;
      RD_DOUT:  rdata = dataOut;
      RD_LVLLO: rdata = lvlLo;
      RD_LVLHI: rdata = lvlHi;
      RD_RISE:  rdata = riseEn;
      RD_FALL:  rdata = fallEn;
      RD_DBEN:  rdata = dbEn;
      RD_DBT:   rdata = PINS'(dbTime);
      default:  rdata = '0;
    endcase
  end

  // R5
  stat_a_clear_only_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(softRst) |-> (($past(statA) & ~statA & ~$past(clrMaskA)) == '0));

  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ($past(cfg[CFG_WEN]) && ($past(cfg[4:3]) != 2'b00)));

  // R7
  out_set_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.outSet) |-> ((dataOut & $past(dataOut)) == $past(dataOut)));

  // R10
  soft_reset_values_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(softRst) |-> (dir == '1 && enA == '0 && enB == '0 && statA == '0
                        && statB == '0 && ctrl == CTRL_RST));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int         PINS   = 32,
  parameter int         ADDR_W = 8,
  parameter int         DBT_W  = 8,
  parameter logic [7:0] REV_ID = 8'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOutEn,
  output logic              irqA,
  output logic              irqB,
  output logic              wakeReq
);

  bankStrobes_t strb;
  rdSel_t       rdSel;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  gpio_bank_dp #(.PINS(PINS), .DBT_W(DBT_W), .REV_ID(REV_ID)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .wdata    (wdata),
    .pinIn    (pinIn),
    .rdata    (rdata),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqA     (irqA),
    .irqB     (irqB),
    .wakeReq  (wakeReq)
  );

endmodule

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOutEn;
  logic        irqA, irqB, wakeReq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  wakeSeen = 1'b0;

  always #4 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .irqA(irqA), .irqB(irqB), .wakeReq(wakeReq)
  );

  always @(posedge clk) if (wakeReq) wakeSeen <= 1'b1;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;    // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 8'h00, 32'h0000_002A, 8'd1},   // R1 revision
    '{1'b0, 8'h14, 32'h0000_0001, 8'd1},   // R1 system status
    '{1'b0, 8'h30, 32'h0000_0002, 8'd1},   // R1 control
    '{1'b0, 8'h34, 32'hFFFF_FFFF, 8'd1},   // R1 direction
    '{1'b1, 8'h1C, 32'h0000_00F0, 8'd7},
    '{1'b1, 8'h64, 32'h0000_0003, 8'd7},
    '{1'b0, 8'h1C, 32'h0000_00F3, 8'd7},   // R7 set alias
    '{1'b1, 8'h60, 32'h0000_0030, 8'd7},
    '{1'b0, 8'h60, 32'h0000_00C3, 8'd7},   // R7 clear alias, alias read
    '{1'b1, 8'h84, 32'h0000_0101, 8'd7},
    '{1'b1, 8'h80, 32'h0000_0001, 8'd7},
    '{1'b0, 8'h20, 32'h0000_0100, 8'd7},   // R7 wakeup aliases
    '{1'b1, 8'h74, 32'h0000_000A, 8'd7},
    '{1'b0, 8'h2C, 32'h0000_000A, 8'd7},   // R7 enable B set alias
    '{1'b1, 8'h30, 32'h0000_00FF, 8'd11},
    '{1'b0, 8'h30, 32'h0000_0007, 8'd11},  // R11 control width
    '{1'b1, 8'h00, 32'h0000_1234, 8'd11},
    '{1'b0, 8'h00, 32'h0000_002A, 8'd11},  // R11 revision read-only
    '{1'b1, 8'h38, 32'h0000_FFFF, 8'd11},
    '{1'b0, 8'h38, 32'h0000_0000, 8'd11},  // R11 data-in read-only
    '{1'b1, 8'h50, 32'hDEAD_BEEF, 8'd13},
    '{1'b0, 8'h50, 32'hDEAD_BEEF, 8'd13},  // R13
    '{1'b1, 8'h54, 32'h0000_01FF, 8'd13},
    '{1'b0, 8'h54, 32'h0000_00FF, 8'd13},  // R13 8-bit time
    '{1'b0, 8'hFC, 32'h0000_0000, 8'd11},  // R11 unmapped
    '{1'b1, 8'h10, 32'h0000_00F9, 8'd10},
    '{1'b0, 8'h10, 32'h0000_0019, 8'd10},  // R10 mask 0x1D
    '{1'b1, 8'h10, 32'h0000_0000, 8'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic hardReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; pinIn = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulsePin(input int p);
    @(negedge clk); pinIn[p] = 1'b1;
    waitCyc(3);
    pinIn[p] = 1'b0;
    waitCyc(3);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hardReset();

    // R1 reset state at the ports
    chk("R1 irqA", {31'b0, irqA}, 32'h0);
    chk("R1 irqB", {31'b0, irqB}, 32'h0);
    chk("R1 wakeReq", {31'b0, wakeReq}, 32'h0);
    chk("R1 pinOutEn", pinOutEn, 32'h0);
    rdChk("R1 status A", 8'h18, 32'h0);
    rdChk("R1 data out", 8'h3C, 32'h0);

    // Register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else begin
        logic [31:0] v;
        rd(VEC[i].a, v);
        checks++;
        if (v !== VEC[i].d) begin
          errors++;
          $display("FAIL table[%0d] R%0d addr=%h actual=%h expected=%h",
                   i, VEC[i].req, VEC[i].a, v, VEC[i].d);
        end
      end
    end

    // R2 / R6 rising edge, two status words, two lines
    hardReset();
    wr(8'h48, 32'h1);
    wr(8'h1C, 32'h1);
    @(negedge clk); pinIn[0] = 1'b1;
    @(negedge clk);
    chk("R2 status not yet set one edge after change", {31'b0, irqA}, 32'h0);
    @(negedge clk);
    chk("R2 R6 irqA two edges after change", {31'b0, irqA}, 32'h1);
    chk("R6 irqB without enable", {31'b0, irqB}, 32'h0);
    rdChk("R2 status A", 8'h18, 32'h1);
    rdChk("R2 status B", 8'h28, 32'h1);
    wr(8'h74, 32'h1);
    chk("R6 irqB after enable set", {31'b0, irqB}, 32'h1);

    // R3 falling edge, no edges on output pins
    hardReset();
    wr(8'h4C, 32'h4);
    wr(8'h48, 32'h40);
    wr(8'h34, ~32'h40);
    @(negedge clk); pinIn[2] = 1'b1;
    waitCyc(3);
    rdChk("R3 rising on fall-only pin", 8'h18, 32'h0);
    pinIn[2] = 1'b0; pinIn[6] = 1'b1;
    waitCyc(3);
    rdChk("R3 falling sets, output pin ignored", 8'h18, 32'h4);

    // R5 write-one-to-clear
    hardReset();
    wr(8'h48, 32'h3);
    @(negedge clk); pinIn[1:0] = 2'b11;
    waitCyc(3);
    rdChk("R5 both set", 8'h18, 32'h3);
    wr(8'h18, 32'h1);
    rdChk("R5 status A partial clear", 8'h18, 32'h2);
    rdChk("R5 status B untouched", 8'h28, 32'h3);

    // R4 level detect re-asserts after clear
    hardReset();
    @(negedge clk); pinIn[3] = 1'b1;
    waitCyc(2);
    wr(8'h44, 32'h8);
    rdChk("R4 high level sets", 8'h18, 32'h8);
    wr(8'h18, 32'h8);
    rdChk("R4 level re-asserts after clear", 8'h18, 32'h8);
    pinIn[3] = 1'b0;
    waitCyc(3);
    wr(8'h18, 32'h8);
    rdChk("R4 clears once level gone", 8'h18, 32'h0);
    wr(8'h40, 32'h10);
    rdChk("R4 low level on status B", 8'h28, 32'h18);

    // R8 / R7 output drive and data-out aliases
    hardReset();
    wr(8'h3C, 32'hFF00_FF00);
    chk("R8 no drive while input", pinOut, 32'h0);
    wr(8'h34, 32'h0000_FFFF);
    chk("R8 pinOut", pinOut, 32'hFF00_0000);
    chk("R8 pinOutEn", pinOutEn, 32'hFFFF_0000);
    wr(8'h94, 32'h1);
    wr(8'h90, 32'hFF00_0000);
    chk("R8 pinOut after clear alias", pinOut, 32'h0);
    rdChk("R7 data out aliases", 8'h94, 32'h0000_FF01);

    // R9 wakeup gating
    hardReset();
    wr(8'h48, 32'h20);
    wr(8'h20, 32'h20);
    wr(8'h10, 32'h04);
    wakeSeen = 1'b0;
    pulsePin(5);
    chk("R9 no wake without idle mode", {31'b0, wakeSeen}, 32'h0);
    wr(8'h10, 32'h0C);
    wakeSeen = 1'b0;
    pulsePin(5);
    chk("R9 wake with enable and idle mode", {31'b0, wakeSeen}, 32'h1);
    wr(8'h80, 32'h20);
    wakeSeen = 1'b0;
    pulsePin(5);
    chk("R9 no wake with pin enable cleared", {31'b0, wakeSeen}, 32'h0);

    // R10 soft reset keeps data out
    hardReset();
    wr(8'h1C, 32'hFF);
    wr(8'h34, 32'h0);
    wr(8'h3C, 32'h55);
    wr(8'h10, 32'h02);
    rdChk("R10 enable A reset", 8'h1C, 32'h0);
    rdChk("R10 direction reset", 8'h34, 32'hFFFF_FFFF);
    rdChk("R10 data out kept", 8'h3C, 32'h55);
    rdChk("R10 config stored", 8'h10, 32'h0);
    wr(8'h10, 32'hFF);
    rdChk("R10 config masked with reset bit", 8'h10, 32'h1D);

    // R12 clear and new event on the same edge
    hardReset();
    wr(8'h48, 32'h10);
    pulsePin(4);
    rdChk("R12 precondition", 8'h18, 32'h10);
    @(negedge clk); pinIn[4] = 1'b1;
    wr(8'h18, 32'h10);
    rdChk("R12 event wins over clear", 8'h18, 32'h10);
    rdChk("R12 status B", 8'h28, 32'h10);
    wr(8'h18, 32'h10);
    rdChk("R12 clear without event", 8'h18, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule